// File: doc/BRIEF.md
# Asynchronous Transmit Retry Scheduler

This block decides when an asynchronous packet from the bulk transmit path is sent again. After each transmission it waits for the acknowledge code from the far node. A busy answer starts a back-off. The back-off is measured in whole isochronous cycles, and the block counts only the cycle-start ticks that arrive while it waits. When the back-off has elapsed, the block raises a resend request and holds it until the packet has gone out again. Any other answer ends the packet at once, and so does a missing acknowledge.

Two 8-bit configuration fields set the behaviour. One field gives how many retries a packet may use, up to 256. The other gives how many isochronous cycles separate two attempts, also up to 256. Retries are single-phase, so only one busy code is honoured. When a packet ends, the block gives a one-cycle done pulse and updates a 32-bit status word with the final acknowledge code and an error flag. Packet storage and bus arbitration stay outside the block. The host-driven control transmit path does not use this block, because it retries by hand.

Top module: `async_retry_sched`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `resend_req` and `done` are 0 and `status` is 32'h0.
- R2: A busy acknowledge (code 4'h4) that arrives while retries remain does not pulse `done` and leaves `status` unchanged. It starts a back-off.
- R3: The back-off counts only cycles in which `cyc_tick` is high. `resend_req` rises in the cycle after the Nth such tick, where N is `cfg_interval`, and a value of 0 means 256 ticks.
- R4: `resend_req` stays high until `sent_pulse` is seen. It is low from the next cycle on.
- R5: Any acknowledge other than busy ends the packet. `done` is high for exactly one cycle after the acknowledge cycle. The code goes into `status[7:4]`, which are bits 24..27 when the bits are numbered from the MSB as bit 0. The error flag is `status[8]` (bit 23 in the same numbering): it is 0 for complete (4'h1) and pending (4'h2), and 1 for any other code.
- R6: A busy acknowledge that arrives after `cfg_retry_limit` retries have been used ends the packet with `done`, the error flag set and code 4'h4. A limit of 0 means 256 retries.
- R7: If `ack_missing` is asserted instead of an acknowledge, the packet ends with `done`, the error flag set and the reserved code 4'hF. No resend follows.
- R8: A `cyc_tick` in the same cycle as the busy acknowledge that starts a back-off does not count towards that back-off.
- R9: While no packet is outstanding, `ack_valid`, `ack_missing` and `cyc_tick` have no effect. `done` stays 0 and `status` keeps its value.
- R10: A `sent_pulse` seen while idle starts a new packet with its full retry budget.
- R11: All `status` bits other than the flag and the code field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_retry_limit | input | 8 | Retries allowed per packet, 0 means 256 |
| cfg_interval | input | 8 | Isochronous cycles between attempts, 0 means 256 |
| sent_pulse | input | 1 | The packet (first or repeated) has been transmitted |
| ack_valid | input | 1 | `ack_code` carries the answer for the outstanding packet |
| ack_code | input | 4 | Acknowledge code from the far node |
| ack_missing | input | 1 | No acknowledge arrived in time |
| cyc_tick | input | 1 | One-cycle pulse at each isochronous cycle start |
| resend_req | output | 1 | Request to transmit the packet again |
| done | output | 1 | One-cycle pulse when the packet has finished |
| status | output | 32 | Last acknowledge result: flag in bit 8, code in bits 7:4 |

## Verification
The busy acknowledge that opens a back-off and a cycle-start tick can arrive in the same clock cycle. In that case the tick must not count towards the new interval. The bench drives `ack_valid` with the busy code and `cyc_tick` in the same cycle, with an interval of 2. It then checks that `resend_req` is still low after one further tick and rises only after the second. A related overlap, an acknowledge or tick that arrives while idle, is checked by confirming that `done` and `status` do not move.

// File: rtl/async_retry_pkg.sv
package async_retry_pkg;

    localparam int CODE_W = 4;
    localparam int STAT_W = 32;

    // Field positions given with the MSB numbered as bit 0, then converted to LSB-based indices.
    localparam int FLAG_POS_MSB0 = 23;
    localparam int CODE_POS_MSB0 = 24;
    localparam int FLAG_IDX      = STAT_W - 1 - FLAG_POS_MSB0;
    localparam int CODE_HI       = STAT_W - 1 - CODE_POS_MSB0;
    localparam int CODE_LO       = CODE_HI - CODE_W + 1;

    typedef logic [CODE_W-1:0] ack_code_t;

    localparam ack_code_t ACK_COMPLETE = 4'h1;
    localparam ack_code_t ACK_PENDING  = 4'h2;
    localparam ack_code_t ACK_BUSY     = 4'h4;
    localparam ack_code_t ACK_ABSENT   = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_ACK,
        ST_BACKOFF,
        ST_RESEND
    } sched_state_e;

    typedef struct packed {
        logic      err;
        ack_code_t code;
    } ack_result_t;

    function automatic logic ack_is_normal(input ack_code_t c);
        return (c == ACK_COMPLETE) || (c == ACK_PENDING);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input ack_result_t r);
        logic [STAT_W-1:0] s;
        s                   = '0;
        s[FLAG_IDX]         = r.err;
        s[CODE_HI:CODE_LO]  = r.code;
        return s;
    endfunction

endpackage

// File: rtl/rts_gap_timer.sv
module rts_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);
    localparam int W = CNT_W + 1;

    logic [W-1:0] remain;
    logic [W-1:0] load_val;

    always_comb begin
        if (interval == '0) load_val = {1'b1, {CNT_W{1'b0}}};
        else                load_val = {1'b0, interval};
    end

    always_ff @(posedge clk) begin
        if (rst)                          remain <= '0;
        else if (load)                    remain <= load_val;
        else if (tick && remain != '0)    remain <= remain - W'(1);
    end

    assign expire = tick && !load && (remain == W'(1));
endmodule

// File: rtl/rts_attempt_ctr.sv
module rts_attempt_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic             exhausted
);
    localparam int W = CNT_W + 1;

    logic [W-1:0] used;
    logic [W-1:0] limit_eff;

    always_comb begin
        if (limit == '0) limit_eff = {1'b1, {CNT_W{1'b0}}};
        else             limit_eff = {1'b0, limit};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) used <= '0;
        else if (bump)    used <= used + W'(1);
    end

    assign exhausted = (used >= limit_eff);
endmodule

// File: rtl/async_retry_sched.sv
module async_retry_sched
    import async_retry_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_retry_limit,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              sent_pulse,
    input  logic              ack_valid,
    input  logic [CODE_W-1:0] ack_code,
    input  logic              ack_missing,
    input  logic              cyc_tick,
    output logic              resend_req,
    output logic              done,
    output logic [STAT_W-1:0] status
);
    sched_state_e st, st_nx;
    ack_result_t  res;
    logic         finish, gap_load, bump, clear;
    logic         expire, exhausted;
    logic         done_q, resend_q;
    logic [STAT_W-1:0] status_q;

    rts_gap_timer #(.CNT_W(CNT_W)) gap_i (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .tick     (cyc_tick),
        .interval (cfg_interval),
        .expire   (expire)
    );

    rts_attempt_ctr #(.CNT_W(CNT_W)) tries_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .bump      (bump),
        .limit     (cfg_retry_limit),
        .exhausted (exhausted)
    );

    always_comb begin
        st_nx    = st;
        finish   = 1'b0;
        gap_load = 1'b0;
        bump     = 1'b0;
        clear    = 1'b0;
        res      = '0;
        case (st)
            ST_IDLE: begin
                if (sent_pulse) begin
                    clear = 1'b1;
                    st_nx = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_valid) begin
                    if (ack_code == ACK_BUSY && !exhausted) begin
                        bump     = 1'b1;
                        gap_load = 1'b1;
                        st_nx    = ST_BACKOFF;
                    end else begin
                        finish   = 1'b1;
                        res.err  = !ack_is_normal(ack_code);
                        res.code = ack_code;
                        st_nx    = ST_IDLE;
                    end
                end else if (ack_missing) begin
                    finish   = 1'b1;
                    res.err  = 1'b1;
                    res.code = ACK_ABSENT;
                    st_nx    = ST_IDLE;
                end
            end
            ST_BACKOFF: begin
                if (expire) st_nx = ST_RESEND;
            end
            ST_RESEND: begin
                if (sent_pulse) st_nx = ST_WAIT_ACK;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            done_q   <= 1'b0;
            resend_q <= 1'b0;
            status_q <= '0;
        end else begin
            st       <= st_nx;
            done_q   <= finish;
            resend_q <= (st_nx == ST_RESEND);
            if (finish) status_q <= pack_status(res);
        end
    end

    assign resend_req = resend_q;
    assign done       = done_q;
    assign status     = status_q;
endmodule

// File: rtl/async_retry_sched_chk.sv
module async_retry_sched_chk
    import async_retry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sent_pulse,
    input logic              cyc_tick,
    input logic              resend_req,
    input logic              done,
    input logic [STAT_W-1:0] status
);
    // R5: the finish indication is a single-cycle pulse
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the request persists until the transmission is reported
    assert_resend_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (resend_req && !sent_pulse) |=> resend_req);

    // R4: the request clears once the transmission is reported
    assert_resend_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (resend_req && sent_pulse) |=> !resend_req);

    // R3: a new request follows a cycle-start tick
    assert_resend_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(resend_req) |-> $past(cyc_tick));

    // R2: status moves only together with a finish pulse
    assert_status_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(status)));

    // R7: the reserved missing-ack code always carries the error flag
    assert_absent_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (done && status[CODE_HI:CODE_LO] == ACK_ABSENT) |-> status[FLAG_IDX]);

    // R11: no bits outside the flag and code field
    assert_status_clean_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(status) == $countones(status[FLAG_IDX:CODE_LO]));

    // R2: a finished packet has no open resend request
    assert_no_resend_on_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !resend_req);
endmodule

bind async_retry_sched async_retry_sched_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .sent_pulse (sent_pulse),
    .cyc_tick   (cyc_tick),
    .resend_req (resend_req),
    .done       (done),
    .status     (status)
);

// File: tb/async_retry_sched_tb_top.sv
module async_retry_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_retry_limit, cfg_interval;
    logic        sent_pulse, ack_valid, ack_missing, cyc_tick;
    logic [3:0]  ack_code;
    logic        resend_req, done;
    logic [31:0] status;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    async_retry_sched dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_retry_limit (cfg_retry_limit),
        .cfg_interval    (cfg_interval),
        .sent_pulse      (sent_pulse),
        .ack_valid       (ack_valid),
        .ack_code        (ack_code),
        .ack_missing     (ack_missing),
        .cyc_tick        (cyc_tick),
        .resend_req      (resend_req),
        .done            (done),
        .status          (status)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send();
        sent_pulse = 1'b1; @(negedge clk); sent_pulse = 1'b0;
    endtask

    task automatic ack(input logic [3:0] c, input logic with_tick);
        ack_valid = 1'b1; ack_code = c; cyc_tick = with_tick;
        @(negedge clk);
        ack_valid = 1'b0; cyc_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1; @(negedge clk); cyc_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "resend in reset", {31'b0, resend_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", {31'b0, done}, 32'd0);
        check("R1", "status after reset", status, 32'h0);
    endtask

    task automatic t_complete();
        cfg_retry_limit = 8'd3; cfg_interval = 8'd2;
        send();
        ack(4'h1, 1'b0);
        check("R5", "done on complete", {31'b0, done}, 32'd1);
        check("R11", "status complete", status, 32'h10);
        @(negedge clk);
        check("R5", "done single cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_error_ack();
        send();
        ack(4'hD, 1'b0);
        check("R5", "done on error ack", {31'b0, done}, 32'd1);
        check("R5", "status error ack", status, 32'h1D0);
    endtask

    task automatic t_busy_retry();
        cfg_retry_limit = 8'd2; cfg_interval = 8'd3;
        send();
        ack(4'h4, 1'b0);
        check("R2", "no done on busy", {31'b0, done}, 32'd0);
        check("R2", "status held on busy", status, 32'h1D0);
        ticks(2);
        check("R3", "no resend before interval", {31'b0, resend_req}, 32'd0);
        ticks(1);
        check("R3", "resend after interval", {31'b0, resend_req}, 32'd1);
        repeat (4) @(negedge clk);
        check("R4", "resend held", {31'b0, resend_req}, 32'd1);
        send();
        check("R4", "resend dropped", {31'b0, resend_req}, 32'd0);
        ack(4'h4, 1'b0);
        ticks(3);
        send();
        ack(4'h4, 1'b0);
        check("R6", "done at limit", {31'b0, done}, 32'd1);
        check("R6", "status at limit", status, 32'h140);
    endtask

    task automatic t_timeout();
        send();
        ack_missing = 1'b1; @(negedge clk); ack_missing = 1'b0;
        check("R7", "done on missing ack", {31'b0, done}, 32'd1);
        check("R7", "status missing ack", status, 32'h1F0);
        ticks(4);
        check("R7", "no resend after missing", {31'b0, resend_req}, 32'd0);
    endtask

    task automatic t_collision();
        cfg_retry_limit = 8'd1; cfg_interval = 8'd2;
        send();
        ack(4'h4, 1'b1);
        ticks(1);
        check("R8", "tick with busy ack ignored", {31'b0, resend_req}, 32'd0);
        ticks(1);
        check("R8", "resend after two later ticks", {31'b0, resend_req}, 32'd1);
        send();
        ack(4'h2, 1'b0);
        check("R5", "status pending", status, 32'h20);
    endtask

    task automatic t_idle_ignore();
        ack(4'hD, 1'b1);
        check("R9", "idle ack no done", {31'b0, done}, 32'd0);
        ack_missing = 1'b1; @(negedge clk); ack_missing = 1'b0;
        check("R9", "idle missing no done", {31'b0, done}, 32'd0);
        ticks(3);
        check("R9", "idle status kept", status, 32'h20);
        check("R9", "idle no resend", {31'b0, resend_req}, 32'd0);
    endtask

    task automatic t_restart();
        cfg_retry_limit = 8'd1; cfg_interval = 8'd1;
        send(); ack(4'h4, 1'b0); ticks(1); send();
        ack(4'h4, 1'b0);
        check("R6", "limit one exhausted", status, 32'h140);
        send();
        ack(4'h4, 1'b0);
        check("R10", "fresh budget no done", {31'b0, done}, 32'd0);
        ticks(1);
        check("R10", "fresh budget resend", {31'b0, resend_req}, 32'd1);
        send(); ack(4'h1, 1'b0);
        check("R10", "fresh packet completes", status, 32'h10);
    endtask

    task automatic t_zero_codes();
        int bad;
        cfg_retry_limit = 8'd1; cfg_interval = 8'd0;
        send(); ack(4'h4, 1'b0);
        ticks(255);
        check("R3", "zero interval at 255 ticks", {31'b0, resend_req}, 32'd0);
        ticks(1);
        check("R3", "zero interval at 256 ticks", {31'b0, resend_req}, 32'd1);
        send(); ack(4'h1, 1'b0);
        cfg_retry_limit = 8'd0; cfg_interval = 8'd1;
        bad = 0;
        send();
        for (int i = 0; i < 256; i++) begin
            ack(4'h4, 1'b0);
            if (done !== 1'b0) bad++;
            ticks(1);
            if (resend_req !== 1'b1) bad++;
            send();
        end
        check("R6", "256 retries allowed", bad, 32'd0);
        ack(4'h4, 1'b0);
        check("R6", "zero limit ends after 256", status, 32'h140);
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; sent_pulse = 1'b0; ack_valid = 1'b0; ack_code = 4'h0;
        ack_missing = 1'b0; cyc_tick = 1'b0;
        cfg_retry_limit = 8'd3; cfg_interval = 8'd2;
        t_reset();
        t_complete();
        t_error_ack();
        t_busy_retry();
        t_timeout();
        t_collision();
        t_idle_ignore();
        t_restart();
        t_zero_codes();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule